// File: doc/BRIEF.md
# Egress Port Set Resolver with VLAN Membership

This block decides which ports of an N-port switch (six by default) a frame may leave through, before any address lookup narrows the set further. A request names the ingress port and the VLAN ID the frame was classified into: the port default, or the ID taken from the tag. One clock later the block returns a registered egress port bitmap and an ingress-drop flag.

Two sets of rules are combined. The first is a per-ingress-port reachability row: a flat bitmap, one row per port, that splits the switch into isolated groups such as two separate bridges of three ports each. The second is a VLAN membership table of up to 16 entries. Each entry holds an ID and a member-port bitmap, and a lookup matches on the ID across all entries at once. A single switch-wide VLAN-aware flag decides whether membership takes part at all. When it is on, the egress set is the AND of both sets, and a frame whose ingress port is not a member of its VLAN is dropped at ingress. When it is off, only the reachability row applies.

Software loads the table through a plain address/data/write-enable port. The flag is loaded through its own write strobe.

Top module: `egress_domain_filter`

## Requirements
- R1: After reset `rsp_valid_o`, `rsp_mask_o`, `rsp_drop_o` and the VLAN-aware flag are all 0, and every table entry is invalid. A request sampled at a rising edge yields `rsp_valid_o`=1 with its result during the following cycle. In any cycle without a response, the mask and drop outputs are 0.
- R2: With the flag on and the ingress port a member of the VLAN, the mask is the ingress port's reachability row ANDed with the VLAN's member bitmap.
- R3: The ingress port's own bit is always 0 in the egress mask.
- R4: With the flag off, VLAN membership is ignored. For a valid ingress port the mask is the reachability row without the ingress bit, and drop is 0.
- R5: With the flag on and the ingress port's bit clear in the VLAN member bitmap, drop is 1 and the mask is 0.
- R6: A VLAN ID that matches no valid table entry has an empty member set. With the flag on, such a frame is therefore dropped.
- R7: A write with `tbl_we_i`=1 stores {valid, ID, members} at `tbl_addr_i`. Writing valid=0 removes that entry from matching.
- R8: When several valid entries carry the same ID, the member set is the OR of their bitmaps (default merge mode).
- R9: An ingress port number of N or more gives drop=1 and mask=0 in either mode.
- R10: A table write or a flag write in the same cycle as a request does not affect that request. The request sees the state before the write, and the next request sees the new state.
- R11: Bit p*N+q of `reach_map_i` set means port p may forward to port q. Row p is bits p*N+N-1 down to p*N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| aware_we_i | input | 1 | Load strobe for the VLAN-aware flag |
| aware_d_i | input | 1 | New value of the VLAN-aware flag |
| reach_map_i | input | N*N | Reachability rows, one row of N bits per ingress port |
| tbl_we_i | input | 1 | Table entry write strobe |
| tbl_addr_i | input | log2(16) | Entry index to write |
| tbl_valid_i | input | 1 | Valid bit of the written entry |
| tbl_vid_i | input | 12 | VLAN ID of the written entry |
| tbl_members_i | input | N | Member bitmap of the written entry |
| req_i | input | 1 | Resolve request strobe |
| req_port_i | input | log2(N) | Ingress port number |
| req_vid_i | input | 12 | Classified VLAN ID of the frame |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| rsp_mask_o | output | N | Egress port bitmap |
| rsp_drop_o | output | 1 | Frame dropped at ingress |

## Verification
The two functions that can collide in one cycle are a table or flag update and a lookup. The bench drives a write and a request at the same falling edge, both aimed at the same VLAN ID or mode. It then checks that the response follows the old contents and that a request in the next cycle follows the new ones. Besides this, the bench sweeps every ingress code (including out-of-range ones), five VLAN IDs (a duplicate, a deleted and a missing one among them), both flag values and three reachability maps against an arithmetic model.

// File: rtl/egress_pkg.sv
package egress_pkg;
   // How several hits for one VLAN ID combine in the membership table
   typedef enum logic {
      MERGE_OR    = 1'b0,
      MERGE_FIRST = 1'b1
   } merge_e;
endpackage

// File: rtl/vlan_member_cam.sv
module vlan_member_cam
   import egress_pkg::*;
#(
   parameter int     NPORTS = 6,
   parameter int     VID_W  = 12,
   parameter int     DEPTH  = 16,
   parameter merge_e MERGE  = MERGE_OR,
   localparam int    AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic              wr_valid,
   input  logic [VID_W-1:0]  wr_vid,
   input  logic [NPORTS-1:0] wr_members,
   input  logic [VID_W-1:0]  lk_vid,
   output logic [NPORTS-1:0] lk_members
);
   logic              ent_vld [DEPTH];
   logic [VID_W-1:0]  ent_vid [DEPTH];
   logic [NPORTS-1:0] ent_mem [DEPTH];
   logic [DEPTH-1:0]  hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_vld[i] <= 1'b0;
            ent_vid[i] <= '0;
            ent_mem[i] <= '0;
         end else if (wr_en && (wr_addr == AW'(i))) begin
            ent_vld[i] <= wr_valid;
            ent_vid[i] <= wr_vid;
            ent_mem[i] <= wr_members;
         end
      end
      assign hit[i] = ent_vld[i] && (ent_vid[i] == lk_vid);
   end

   if (MERGE == MERGE_OR) begin : g_merge_or
      always_comb begin
         lk_members = '0;
         for (int i = 0; i < DEPTH; i++)
            if (hit[i]) lk_members = lk_members | ent_mem[i];
      end
   end else begin : g_merge_first
      always_comb begin
         lk_members = '0;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (hit[i]) lk_members = ent_mem[i];
      end
   end
endmodule

// File: rtl/domain_row_select.sv
module domain_row_select #(
   parameter int  NPORTS = 6,
   localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic [NPORTS*NPORTS-1:0] reach_map,
   input  logic [PW-1:0]            port,
   output logic [NPORTS-1:0]        row,
   output logic                     port_ok
);
   always_comb begin
      row     = '0;
      port_ok = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
         if (port == PW'(p)) begin
            port_ok = 1'b1;
            row     = reach_map[p*NPORTS +: NPORTS];
            row[p]  = 1'b0;
         end
      end
   end
endmodule

// File: rtl/egress_resolve.sv
module egress_resolve #(
   parameter int  NPORTS = 6,
   localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              aware,
   input  logic              port_ok,
   input  logic [PW-1:0]     port,
   input  logic [NPORTS-1:0] row,
   input  logic [NPORTS-1:0] members,
   output logic              rsp_valid,
   output logic [NPORTS-1:0] rsp_mask,
   output logic              rsp_drop
);
   logic              self_member;
   logic [NPORTS-1:0] nxt_mask;
   logic              nxt_drop;

   assign self_member = |(members & (NPORTS'(1) << port));

   always_comb begin
      nxt_mask = '0;
      nxt_drop = 1'b0;
      if (!port_ok) begin
         nxt_drop = 1'b1;
      end else if (!aware) begin
         nxt_mask = row;
      end else if (!self_member) begin
         nxt_drop = 1'b1;
      end else begin
         nxt_mask = row & members;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_mask  <= '0;
         rsp_drop  <= 1'b0;
      end else begin
         rsp_valid <= req;
         rsp_mask  <= req ? nxt_mask : '0;
         rsp_drop  <= req & nxt_drop;
      end
   end
endmodule

// File: rtl/egress_domain_filter.sv
module egress_domain_filter
   import egress_pkg::*;
#(
   parameter int     NPORTS = 6,
   parameter int     VID_W  = 12,
   parameter int     DEPTH  = 16,
   parameter merge_e MERGE  = MERGE_OR,
   localparam int    PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int    AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int    MAPW   = NPORTS * NPORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aware_we_i,
   input  logic              aware_d_i,
   input  logic [MAPW-1:0]   reach_map_i,
   input  logic              tbl_we_i,
   input  logic [AW-1:0]     tbl_addr_i,
   input  logic              tbl_valid_i,
   input  logic [VID_W-1:0]  tbl_vid_i,
   input  logic [NPORTS-1:0] tbl_members_i,
   input  logic              req_i,
   input  logic [PW-1:0]     req_port_i,
   input  logic [VID_W-1:0]  req_vid_i,
   output logic              rsp_valid_o,
   output logic [NPORTS-1:0] rsp_mask_o,
   output logic              rsp_drop_o
);
   if (NPORTS < 2 || NPORTS > 32) begin : g_bad_nports
      $error("egress_domain_filter: NPORTS must lie in 2..32");
   end
   if (DEPTH < 1 || DEPTH > 256) begin : g_bad_depth
      $error("egress_domain_filter: DEPTH must lie in 1..256");
   end
   if (VID_W < 1 || VID_W > 16) begin : g_bad_vidw
      $error("egress_domain_filter: VID_W must lie in 1..16");
   end

   logic              aware_q;
   logic [NPORTS-1:0] members;
   logic [NPORTS-1:0] row;
   logic              port_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          aware_q <= 1'b0;
      else if (aware_we_i) aware_q <= aware_d_i;
   end

   vlan_member_cam #(
      .NPORTS(NPORTS), .VID_W(VID_W), .DEPTH(DEPTH), .MERGE(MERGE)
   ) u_cam (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_we_i),
      .wr_addr    (tbl_addr_i),
      .wr_valid   (tbl_valid_i),
      .wr_vid     (tbl_vid_i),
      .wr_members (tbl_members_i),
      .lk_vid     (req_vid_i),
      .lk_members (members)
   );

   domain_row_select #(.NPORTS(NPORTS)) u_row (
      .reach_map (reach_map_i),
      .port      (req_port_i),
      .row       (row),
      .port_ok   (port_ok)
   );

   egress_resolve #(.NPORTS(NPORTS)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_i),
      .aware     (aware_q),
      .port_ok   (port_ok),
      .port      (req_port_i),
      .row       (row),
      .members   (members),
      .rsp_valid (rsp_valid_o),
      .rsp_mask  (rsp_mask_o),
      .rsp_drop  (rsp_drop_o)
   );
endmodule

// File: rtl/egress_domain_filter_chk.sv
module egress_domain_filter_chk #(
   parameter int  NPORTS = 6,
   localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int MAPW   = NPORTS * NPORTS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [PW-1:0]     req_port_i,
   input logic [MAPW-1:0]   reach_map_i,
   input logic              aware_q,
   input logic              rsp_valid_o,
   input logic [NPORTS-1:0] rsp_mask_o,
   input logic              rsp_drop_o
);
   logic [NPORTS-1:0] self_bit;
   logic [NPORTS-1:0] raw_row;
   logic              in_range;

   always_comb begin
      self_bit = NPORTS'(1) << req_port_i;
      in_range = int'(req_port_i) < NPORTS;
      raw_row  = '0;
      for (int p = 0; p < NPORTS; p++)
         if (int'(req_port_i) == p) raw_row = reach_map_i[p*NPORTS +: NPORTS];
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> rsp_valid_o);                                              // R1
   AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!rsp_valid_o && rsp_mask_o == '0 && !rsp_drop_o));       // R1
   AST_WITHIN_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> ((rsp_mask_o & ~$past(raw_row)) == '0));             // R2
   AST_SELF_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> ((rsp_mask_o & $past(self_bit)) == '0));             // R3
   AST_UNAWARE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !$past(aware_q) && $past(in_range)) |-> !rsp_drop_o); // R4
   AST_DROP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_drop_o |-> (rsp_mask_o == '0));                                  // R5
   AST_BAD_PORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !$past(in_range)) |-> rsp_drop_o);                   // R9
endmodule

bind egress_domain_filter egress_domain_filter_chk #(.NPORTS(NPORTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .req_port_i  (req_port_i),
   .reach_map_i (reach_map_i),
   .aware_q     (aware_q),
   .rsp_valid_o (rsp_valid_o),
   .rsp_mask_o  (rsp_mask_o),
   .rsp_drop_o  (rsp_drop_o)
);

// File: tb/egress_domain_filter_test.sv
module egress_domain_filter_test;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 6;
   localparam int VW   = 12;
   localparam int D    = 16;
   localparam int PW   = 3;
   localparam int AW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            aware_we = 1'b0, aware_d = 1'b0;
   logic [N*N-1:0]  reach_map = '0;
   logic            tbl_we = 1'b0, tbl_valid = 1'b0;
   logic [AW-1:0]   tbl_addr = '0;
   logic [VW-1:0]   tbl_vid = '0;
   logic [N-1:0]    tbl_members = '0;
   logic            req = 1'b0;
   logic [PW-1:0]   req_port = '0;
   logic [VW-1:0]   req_vid = '0;
   logic            rsp_valid, rsp_drop;
   logic [N-1:0]    rsp_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the table and the flag
   bit           m_vld [D];
   int           m_vid [D];
   bit [N-1:0]   m_mem [D];
   bit           m_aware = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   egress_domain_filter uut (
      .clk(clk), .rst_n(rst_n), .aware_we_i(aware_we), .aware_d_i(aware_d),
      .reach_map_i(reach_map), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
      .tbl_valid_i(tbl_valid), .tbl_vid_i(tbl_vid), .tbl_members_i(tbl_members),
      .req_i(req), .req_port_i(req_port), .req_vid_i(req_vid),
      .rsp_valid_o(rsp_valid), .rsp_mask_o(rsp_mask), .rsp_drop_o(rsp_drop)
   );

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit [N*N-1:0] make_map(int kind);
      bit [N*N-1:0] m = '0;
      for (int p = 0; p < N; p++)
         for (int q = 0; q < N; q++) begin
            bit en;
            if (kind == 0)      en = ((p < 3) == (q < 3));  // two isolated groups
            else if (kind == 1) en = 1'b1;                    // fully open
            else                en = (q != ((p + 1) % N));    // asymmetric holes
            m[p*N + q] = en;
         end
      return m;
   endfunction

   task automatic write_entry(int addr, bit v, int vid, bit [N-1:0] mem);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = AW'(addr); tbl_valid = v;
      tbl_vid = VW'(vid); tbl_members = mem;
      @(negedge clk);
      tbl_we = 1'b0;
      m_vld[addr] = v; m_vid[addr] = vid; m_mem[addr] = mem;
   endtask

   task automatic set_aware(bit a);
      @(negedge clk);
      aware_we = 1'b1; aware_d = a;
      @(negedge clk);
      aware_we = 1'b0;
      m_aware = a;
   endtask

   function automatic void model(int port, int vid, output bit [N-1:0] mask,
                                 output bit drop, output string tag);
      bit [N-1:0] mem = '0;
      bit [N-1:0] row;
      bit hit = 1'b0;
      for (int i = 0; i < D; i++)
         if (m_vld[i] && m_vid[i] == vid) begin mem |= m_mem[i]; hit = 1'b1; end
      mask = '0; drop = 1'b0;
      if (port >= N) begin drop = 1'b1; tag = "R9"; return; end
      row = reach_map[port*N +: N];
      row[port] = 1'b0;
      if (!m_aware) begin mask = row; tag = "R4"; end
      else if (!mem[port]) begin drop = 1'b1; tag = hit ? "R5" : "R6"; end
      else begin mask = row & mem; tag = "R2"; end
   endfunction

   // drives one request; the response is registered at the next rising edge
   task automatic lookup(int port, int vid, string tag_override);
      bit [N-1:0] em; bit ed; string tag;
      model(port, vid, em, ed, tag);
      if (tag_override != "") tag = tag_override;
      @(negedge clk);
      req = 1'b1; req_port = PW'(port); req_vid = VW'(vid);
      @(negedge clk);
      req = 1'b0;
      check(tag, "valid", 32'(rsp_valid), 32'd1);
      check(tag, "mask",  32'(rsp_mask),  32'(em));
      check(tag, "drop",  32'(rsp_drop),  32'(ed));
      if (port < N) check("R3", "self bit", 32'(rsp_mask[port]), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int vids [5] = '{10, 20, 30, 40, 50};
      for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_vid[i] = 0; m_mem[i] = '0; end
      repeat (3) @(negedge clk);
      // reset state R1
      check("R1", "reset valid", 32'(rsp_valid), 32'd0);
      check("R1", "reset mask",  32'(rsp_mask),  32'd0);
      check("R1", "reset drop",  32'(rsp_drop),  32'd0);
      rst_n = 1'b1;
      reach_map = make_map(1);
      // flag off after reset: membership ignored
      lookup(0, 10, "R4");
      @(negedge clk);
      check("R1", "idle valid", 32'(rsp_valid), 32'd0);
      check("R1", "idle mask",  32'(rsp_mask),  32'd0);
      // empty table after reset, flag on: every VID misses (R7 reset state)
      set_aware(1'b1);
      lookup(2, 10, "R6");

      // load table: duplicate ID 20 (R8), deleted ID 40 (R7)
      write_entry(0, 1, 10, 6'b000111);
      write_entry(1, 1, 20, 6'b111000);
      write_entry(2, 1, 30, 6'b111111);
      write_entry(3, 1, 20, 6'b000001);
      write_entry(4, 1, 40, 6'b111111);
      write_entry(4, 0, 40, 6'b111111);

      // R8: port 0 is member of ID 20 only through entry 3
      reach_map = make_map(1);
      lookup(0, 20, "R8");
      check("R8", "merged mask", 32'(rsp_mask), 32'h38);
      // R7: deleted entry no longer matches
      lookup(1, 40, "R7");
      check("R7", "deleted drop", 32'(rsp_drop), 32'd1);
      // R11: row encoding, map 2 port 2 may not reach port 3
      reach_map = make_map(2);
      lookup(2, 30, "R11");
      check("R11", "row hole", 32'(rsp_mask), 32'h33);

      // sweep
      for (int k = 0; k < 3; k++) begin
         reach_map = make_map(k);
         for (int a = 0; a < 2; a++) begin
            set_aware(a[0]);
            for (int p = 0; p < 8; p++)
               for (int v = 0; v < 5; v++)
                  lookup(p, vids[v], "");
         end
      end

      // R10: write and request in the same cycle see the old table
      reach_map = make_map(1);
      set_aware(1'b1);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = AW'(5); tbl_valid = 1'b1;
      tbl_vid = VW'(50); tbl_members = 6'b010010;
      req = 1'b1; req_port = PW'(1); req_vid = VW'(50);
      @(negedge clk);
      tbl_we = 1'b0; req = 1'b0;
      check("R10", "old table drop", 32'(rsp_drop), 32'd1);
      check("R10", "old table mask", 32'(rsp_mask), 32'd0);
      m_vld[5] = 1; m_vid[5] = 50; m_mem[5] = 6'b010010;
      lookup(1, 50, "R10");
      check("R10", "new table mask", 32'(rsp_mask), 32'h10);
      // R10: flag write and request in the same cycle
      @(negedge clk);
      aware_we = 1'b1; aware_d = 1'b0;
      req = 1'b1; req_port = PW'(0); req_vid = VW'(50);
      @(negedge clk);
      aware_we = 1'b0; req = 1'b0;
      check("R10", "old flag drop", 32'(rsp_drop), 32'd1);
      m_aware = 1'b0;
      lookup(0, 50, "R10");
      check("R10", "new flag mask", 32'(rsp_mask), 32'h3E);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule